// File: doc/BRIEF.md
# Banked Data Memory Address Mapper

This block sits between the operand path of a small 8-bit processor core and its data store. For each access it takes the 7-bit operand address from the instruction, the current bank bit and the 8-bit value of the pointer register, and resolves them to one target. That target is a location in a 68-byte general-purpose RAM held inside the block, one of twelve special-function register slots, or nothing at all.

Address 00h has no storage of its own. Any access to it follows the pointer register instead, and that redirected access still uses the bank bit currently selected. The general-purpose window 0Ch..4Fh is the same in both banks, so an access from bank 1 lands on the bank 0 byte and raises a mirror flag. Special-function slots 00h..0Bh are selected one-hot. The peripheral side supplies their read data, and it uses the bank bit to tell the two banks apart. Addresses 50h..7Fh are unimplemented.

Top module: `dmem_bank_mapper`

## Requirements
- R1: A direct access with operand address A in 0Ch..4Fh drives gpr_hit high and phys_addr = A - 0Ch. A write at such an address is stored, and a later read of the same address returns that byte.
- R2: With bank_sel = 1, an address in 0Ch..4Fh reaches the same RAM byte as with bank_sel = 0, and mirror is 1. mirror is 0 for every other access.
- R3: An effective address E in 01h..0Bh sets only bit E of sfr_sel and returns sfr_rdata on rd_data. It leaves gpr_hit low and changes no RAM byte.
- R4: Effective addresses 50h..7Fh, in either bank, return rd_data = 0 and assert no select. A write to them changes no RAM byte.
- R5: Operand address 00h is replaced by ind_ptr[6:0], and ind_ptr[7] is ignored. bank_sel still decides mirror for the redirected access.
- R6: If operand address 00h meets a pointer whose low 7 bits are 00h, rd_data is 0, no select is asserted and nothing is written.
- R7: A RAM write takes effect at the rising clock edge. rd_data follows the address inputs without a clock.
- R8: At most one sfr_sel bit is high, and gpr_hit is never high in the same cycle as any sfr_sel bit.
- R9: While rst_n is low, no RAM write takes place. Reset does not clear RAM contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; RAM writes on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes while low |
| dir_addr | input | 7 | Operand address from the instruction |
| bank_sel | input | 1 | Current bank bit (0 = bank 0, 1 = bank 1) |
| ind_ptr | input | 8 | Pointer register value; low 7 bits used |
| wr_en | input | 1 | Write strobe for the resolved location |
| wr_data | input | 8 | Byte to write |
| sfr_rdata | input | 8 | Read data from the selected special-function register |
| rd_data | output | 8 | Read data of the resolved location |
| phys_addr | output | 7 | RAM index 0..67 when gpr_hit, else 0 |
| gpr_hit | output | 1 | Access targets general-purpose RAM |
| sfr_sel | output | 12 | One-hot special-function register select |
| mirror | output | 1 | Bank 1 access folded onto bank 0 RAM |

## Verification
The only state in the block is the RAM array. A wrong fold or a wrong offset therefore shows up as a byte stored in the wrong place, and it becomes visible at the first read of the address that should hold the byte, which can be many cycles later. The bench therefore reads back through both banks and through the pointer after each group of writes. It also rereads a known byte after every write that should have no effect (null pointer, unimplemented address, reset), so that a stray write shows on the very next read. Decode errors have no latency: they appear on gpr_hit, sfr_sel, mirror or rd_data in the same cycle as the address.

// File: rtl/dmem_bank_mapper.sv
module dmem_bank_mapper #(
  parameter int AW       = 7,
  parameter int DW       = 8,
  parameter int SFR_CNT  = 12,
  parameter int GPR_CNT  = 68,
  parameter int IND_ADDR = 0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [AW-1:0]                dir_addr,
  input  logic                         bank_sel,
  input  logic [DW-1:0]                ind_ptr,
  input  logic                         wr_en,
  input  logic [DW-1:0]                wr_data,
  input  logic [DW-1:0]                sfr_rdata,
  output logic [DW-1:0]                rd_data,
  output logic [$clog2(GPR_CNT)-1:0]   phys_addr,
  output logic                         gpr_hit,
  output logic [SFR_CNT-1:0]           sfr_sel,
  output logic                         mirror
);
  localparam int PW = $clog2(GPR_CNT);
  localparam logic [AW-1:0] IND_A  = AW'(IND_ADDR);
  localparam logic [AW-1:0] GPR_LO = AW'(SFR_CNT);
  localparam logic [AW-1:0] GPR_HI = AW'(SFR_CNT + GPR_CNT - 1);

  logic [DW-1:0] mem [GPR_CNT];
  logic [AW-1:0] eff, offs;
  logic          null_acc, sfr_hit;

  wire unused_ok = &{1'b0, ind_ptr[DW-1:AW]};

  assign eff      = (dir_addr == IND_A) ? ind_ptr[AW-1:0] : dir_addr;
  assign null_acc = (eff == IND_A);
  assign sfr_hit  = !null_acc && (eff < GPR_LO);
  assign gpr_hit  = !null_acc && (eff >= GPR_LO) && (eff <= GPR_HI);
  assign offs     = eff - GPR_LO;
  assign phys_addr = gpr_hit ? offs[PW-1:0] : '0;
  assign mirror   = gpr_hit && bank_sel;

  for (genvar i = 0; i < SFR_CNT; i++) begin : g_sel
    assign sfr_sel[i] = sfr_hit && (eff == AW'(i));
  end

  always_ff @(posedge clk)
    if (rst_n && wr_en && gpr_hit)
      mem[phys_addr] <= wr_data;

  assign rd_data = gpr_hit ? mem[phys_addr] :
                   sfr_hit ? sfr_rdata      : '0;
endmodule

module dmem_bank_mapper_chk #(
  parameter int AW = 7, DW = 8, SFR_CNT = 12, GPR_CNT = 68
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [AW-1:0]              dir_addr,
  input logic                       bank_sel,
  input logic [DW-1:0]              ind_ptr,
  input logic                       wr_en,
  input logic [DW-1:0]              wr_data,
  input logic [DW-1:0]              rd_data,
  input logic [$clog2(GPR_CNT)-1:0] phys_addr,
  input logic                       gpr_hit,
  input logic [SFR_CNT-1:0]         sfr_sel,
  input logic                       mirror
);
  a_r8_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sfr_sel));

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(gpr_hit && (sfr_sel != '0)));

  a_r2_mirror_only_gpr: assert property (@(posedge clk) disable iff (!rst_n)
    mirror |-> (gpr_hit && bank_sel));

  a_r4_unimpl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_addr >= AW'(SFR_CNT + GPR_CNT)) |-> (!gpr_hit && sfr_sel == '0 && rd_data == '0));

  a_r6_null_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_addr == '0 && ind_ptr[AW-1:0] == '0) |-> (!gpr_hit && sfr_sel == '0 && rd_data == '0));

  a_r7_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en && gpr_hit) && gpr_hit && phys_addr == $past(phys_addr))
      |-> (rd_data == $past(wr_data)));

  a_r1_phys_range: assert property (@(posedge clk) disable iff (!rst_n)
    gpr_hit |-> (phys_addr < ($clog2(GPR_CNT))'(GPR_CNT)));
endmodule

bind dmem_bank_mapper dmem_bank_mapper_chk #(
  .AW(AW), .DW(DW), .SFR_CNT(SFR_CNT), .GPR_CNT(GPR_CNT)
) chk (
  .clk(clk), .rst_n(rst_n), .dir_addr(dir_addr), .bank_sel(bank_sel),
  .ind_ptr(ind_ptr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .phys_addr(phys_addr), .gpr_hit(gpr_hit), .sfr_sel(sfr_sel), .mirror(mirror)
);

// File: tb/dmem_bank_mapper_test.sv
`timescale 1ns/100ps
module dmem_bank_mapper_test;
  logic        clk = 0, rst_n = 0;
  logic [6:0]  dir_addr = 0;
  logic        bank_sel = 0;
  logic [7:0]  ind_ptr = 0, wr_data = 0;
  logic        wr_en = 0;
  logic [7:0]  sfr_rdata = 8'hC3;
  logic [7:0]  rd_data;
  logic [6:0]  phys_addr;
  logic        gpr_hit, mirror;
  logic [11:0] sfr_sel;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct {
    logic [7:0]  rd;
    logic [6:0]  phys;
    logic        gpr;
    logic [11:0] sel;
    logic        mir;
    string       tag;
  } exp_t;

  exp_t q[$];
  logic [7:0] model [68];

  dmem_bank_mapper uut (
    .clk(clk), .rst_n(rst_n), .dir_addr(dir_addr), .bank_sel(bank_sel),
    .ind_ptr(ind_ptr), .wr_en(wr_en), .wr_data(wr_data), .sfr_rdata(sfr_rdata),
    .rd_data(rd_data), .phys_addr(phys_addr), .gpr_hit(gpr_hit),
    .sfr_sel(sfr_sel), .mirror(mirror)
  );

  always #2.5 clk = ~clk;

  task automatic acc(input logic [6:0] a, input logic b, input logic [7:0] p,
                     input logic we, input logic [7:0] d, input string tag);
    exp_t e;
    logic [6:0] eff;
    @(negedge clk);
    dir_addr = a; bank_sel = b; ind_ptr = p; wr_en = we; wr_data = d;
    eff = (a == 7'h00) ? p[6:0] : a;
    e.rd = 8'h00; e.phys = 7'h00; e.gpr = 0; e.sel = '0; e.mir = 0; e.tag = tag;
    if (eff == 7'h00) begin
    end else if (eff < 7'h0C) begin
      e.sel = 12'(1) << eff; e.rd = sfr_rdata;
    end else if (eff <= 7'h4F) begin
      e.gpr = 1; e.phys = eff - 7'h0C; e.rd = model[e.phys]; e.mir = b;
    end
    q.push_back(e);
    if (we && rst_n && e.gpr) model[e.phys] = d;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk); #1;
      if (q.size() != 0) begin
        e = q.pop_front();
        total++;
        if (rd_data !== e.rd || phys_addr !== e.phys || gpr_hit !== e.gpr ||
            sfr_sel !== e.sel || mirror !== e.mir) begin
          bad++;
          $display("FAIL %s: got rd=%h phys=%h gpr=%b sel=%h mir=%b exp rd=%h phys=%h gpr=%b sel=%h mir=%b",
                   e.tag, rd_data, phys_addr, gpr_hit, sfr_sel, mirror,
                   e.rd, e.phys, e.gpr, e.sel, e.mir);
        end
      end
    end
  end

  initial begin : watchdog
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got running exp finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    acc(7'h50, 0, 0, 0, 0, "R4 reset-state unimplemented read");
    rst_n = 1;
    // R1 fill every byte, then read back through bank 0 and R2 bank 1
    for (int i = 0; i < 68; i++) acc(7'(i + 12), i[0], 0, 1, 8'(i) ^ 8'h5A, "R1 fill");
    for (int i = 0; i < 68; i++) acc(7'(i + 12), 0, 0, 0, 0, "R1 readback bank0");
    for (int i = 0; i < 68; i++) acc(7'(i + 12), 1, 0, 0, 0, "R2 readback bank1");
    acc(7'h30, 1, 0, 1, 8'h3C, "R2 write bank1");
    acc(7'h30, 0, 0, 0, 0, "R2 bank0 sees bank1 write");
    acc(7'h0C, 0, 0, 1, 8'h11, "R7 write low edge");
    acc(7'h0C, 0, 0, 0, 0, "R7 next-cycle read");
    acc(7'h4F, 0, 0, 1, 8'hA5, "R1 write top byte");
    acc(7'h4F, 1, 0, 0, 0, "R2 top byte via bank1");
    // R3 SFR decode
    for (int i = 1; i < 12; i++) acc(7'(i), i[0], 0, 1, 8'hEE, "R3 sfr select");
    acc(7'h0C, 0, 0, 0, 0, "R3 sfr writes leave RAM");
    // R4 unimplemented
    acc(7'h50, 0, 0, 1, 8'hEE, "R4 write 50h");
    acc(7'h7F, 1, 0, 1, 8'hEE, "R4 write 7Fh bank1");
    acc(7'h0C, 0, 0, 0, 0, "R4 RAM intact after unimpl write");
    acc(7'h4F, 0, 0, 0, 0, "R4 top byte intact");
    // R5 indirect
    acc(7'h00, 0, 8'h0C, 0, 0, "R5 indirect read");
    acc(7'h00, 0, 8'h8C, 0, 0, "R5 pointer bit7 ignored");
    acc(7'h00, 1, 8'h4F, 0, 0, "R5 indirect bank1 mirror");
    acc(7'h00, 1, 8'hA0, 1, 8'h5A, "R5 indirect write");
    acc(7'h20, 0, 0, 0, 0, "R5 direct sees indirect write");
    acc(7'h00, 0, 8'h04, 0, 0, "R5 indirect to sfr");
    acc(7'h00, 0, 8'h60, 1, 8'h99, "R5 indirect unimplemented");
    // R6 null pointer
    acc(7'h00, 0, 8'h00, 1, 8'h77, "R6 null pointer write");
    acc(7'h00, 1, 8'h80, 1, 8'h77, "R6 null pointer bit7 set");
    acc(7'h0C, 0, 0, 0, 0, "R6 RAM intact");
    acc(7'h20, 1, 0, 0, 0, "R6 RAM intact bank1");
    // R9 reset blocks writes, keeps contents
    @(negedge clk); rst_n = 0;
    acc(7'h0C, 0, 0, 1, 8'h99, "R9 write during reset");
    acc(7'h0C, 0, 0, 0, 0, "R9 read during reset");
    @(negedge clk); rst_n = 1;
    acc(7'h0C, 0, 0, 0, 0, "R9 contents kept after reset");
    acc(7'h30, 1, 0, 0, 0, "R9 contents kept bank1");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule